// File: doc/BRIEF.md
# Fixed Time-Slot Shared Pipeline Arbiter

This block lets four requesters share one single-issue, in-order pipeline without any of them being able to observe the others. A free-running two-bit slot counter hands the pipeline's issue port to one requester per cycle in strict rotation. A requester may only start work in its own slot. If it leaves its slot idle, the slot goes out empty, even when other requesters have work waiting. The result is that grant timing and result timing for any one requester depend only on its own traffic.

Some operations need more than one trip through the pipeline. The issue port tells the pipeline how many passes are still to come, and the pipeline tail returns that count with the partial result. When the tail shows passes still to run, the operation is parked in a holding register that belongs to its owner. It goes back into the pipeline at the next slot that owner holds. Finished operations are steered back to the requester named by the two-bit owner tag they carried through the pipeline. The pipeline itself is outside this block.

Top module: `slot_arbiter`

## Requirements
- R1: The slot counter is 0 in the first cycle after reset and advances by one, wrapping modulo 4, every cycle; `slot_owner` shows its value.
- R2: Requester k is granted only in a cycle where `slot_owner` equals k, provided its request is valid and no recirculating operation of k is waiting. The grant is combinational in that same cycle.
- R3: No slot is ever given to a requester other than its owner. When the owner has nothing to issue, `iss_valid` stays 0 in that cycle whatever other requests are pending.
- R4: A new issue carries `iss_owner` equal to the requester index, `iss_data` equal to that requester's operand lane (lane k is bits k*32 upward), and `iss_left` equal to its `req_extra` field. `req_extra` is the number of passes after the first.
- R5: A tail return with `tail_left` not zero is held for its owner. It is reissued at the first owner slot strictly after the tail cycle, with `tail_data` unchanged and `iss_left` equal to `tail_left` minus 1.
- R6: In its own slot, a waiting recirculation is issued in place of a new request from the same requester, and that request gets no grant in that cycle.
- R7: A tail return with `tail_valid` 1 and `tail_left` 0 raises `res_valid[tail_owner]` in the same cycle, with `tail_data` on that owner's result lane. All other lanes read 0 with their valid low.
- R8: The grant cycles, result cycles and result values seen by one requester are identical under any activity of the other three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Per-requester request, bit k for requester k |
| req_data | input | 128 | Operand lanes, 32 bits per requester |
| req_extra | input | 12 | Extra pass count lanes, 3 bits per requester |
| req_grant | output | 4 | Per-requester grant, combinational |
| slot_owner | output | 2 | Requester that owns the current cycle |
| iss_valid | output | 1 | Pipeline issue valid |
| iss_owner | output | 2 | Owner tag of the issued operation |
| iss_left | output | 3 | Passes still to run after this one |
| iss_data | output | 32 | Issued operand |
| tail_valid | input | 1 | Pipeline tail valid |
| tail_owner | input | 2 | Owner tag at the tail |
| tail_left | input | 3 | Passes still to run for the tail operation |
| tail_data | input | 32 | Partial or final result at the tail |
| res_valid | output | 4 | Completed result valid, one bit per requester |
| res_data | output | 128 | Result lanes, 32 bits per requester |

## Verification
The bench targets the moment when one requester's slot is empty while the others have requests pending. A design that lets another requester take that slot shows an extra grant and a nonzero `iss_valid` there. It also drives recirculations whose tail cycle falls just before, on and after the owner's slot, with a fresh request pending at the same time. A design that reissues early, in the wrong slot, or lets the new request win shows misplaced grants and wrong `iss_left` or `iss_data`. Finally, it replays one requester's fixed random pattern twice, once alone and once against heavy random traffic on the other three. Any difference in that requester's grant or result trace exposes a leak between requesters.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
    localparam int NREQ   = 4;
    localparam int ID_W   = $clog2(NREQ);
    localparam int DATA_W = 32;
    localparam int PASS_W = 3;

    typedef logic [ID_W-1:0]   owner_t;
    typedef logic [PASS_W-1:0] passes_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic    valid;
        owner_t  owner;
        passes_t left;
        word_t   data;
    } pipe_op_t;

    localparam pipe_op_t OP_NONE = '{valid: 1'b0, owner: '0, left: '0, data: '0};

    function automatic logic needs_more(input pipe_op_t op);
        return op.valid && (op.left != '0);
    endfunction

    function automatic logic is_done(input pipe_op_t op);
        return op.valid && (op.left == '0);
    endfunction
endpackage

// File: rtl/slot_counter.sv
module slot_counter
    import slot_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output owner_t slot
);
    owner_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + owner_t'(1);
    end

    assign slot = cnt_q;

    assert_slot_reset_R1: assert property (@(posedge clk) rst |=> (slot == '0));
    assert_slot_step_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot == $past(slot) + owner_t'(1)));
endmodule

// File: rtl/recirc_hold.sv
module recirc_hold
    import slot_arb_pkg::*;
#(
    parameter int OWNER = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  pipe_op_t tail,
    input  logic     take,
    output pipe_op_t held
);
    pipe_op_t hold_q;
    logic     capture;

    assign capture = needs_more(tail) && (tail.owner == owner_t'(OWNER));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= OP_NONE;
        end else if (capture) begin
            hold_q.valid <= 1'b1;
            hold_q.owner <= tail.owner;
            hold_q.left  <= tail.left - passes_t'(1);
            hold_q.data  <= tail.data;
        end else if (take) begin
            hold_q.valid <= 1'b0;
        end
    end

    assign held = hold_q;

    assert_hold_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
        (capture && hold_q.valid) |-> take);
    assert_hold_take_valid_R5: assert property (@(posedge clk) disable iff (rst)
        take |-> hold_q.valid);
endmodule

// File: rtl/issue_select.sv
module issue_select
    import slot_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  owner_t                slot,
    input  pipe_op_t              held [NREQ],
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ*DATA_W-1:0] req_data,
    input  logic [NREQ*PASS_W-1:0] req_extra,
    output logic [NREQ-1:0]        grant,
    output logic [NREQ-1:0]        take,
    output pipe_op_t              iss
);
    always_comb begin
        grant = '0;
        take  = '0;
        iss   = OP_NONE;
        for (int k = 0; k < NREQ; k++) begin
            if (slot == owner_t'(k)) begin
                if (held[k].valid) begin
                    take[k] = 1'b1;
                    iss     = held[k];
                end else if (req_valid[k]) begin
                    grant[k]  = 1'b1;
                    iss.valid = 1'b1;
                    iss.owner = owner_t'(k);
                    iss.left  = req_extra[k*PASS_W +: PASS_W];
                    iss.data  = req_data[k*DATA_W +: DATA_W];
                end
            end
        end
    end

    assert_one_grant_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && $onehot0(take));
    assert_recirc_first_R6: assert property (@(posedge clk) disable iff (rst)
        held[slot].valid |-> (grant == '0));
endmodule

// File: rtl/result_router.sv
module result_router
    import slot_arb_pkg::*;
(
    input  pipe_op_t              tail,
    output logic [NREQ-1:0]        res_valid,
    output logic [NREQ*DATA_W-1:0] res_data
);
    always_comb begin
        res_valid = '0;
        res_data  = '0;
        for (int k = 0; k < NREQ; k++) begin
            if (is_done(tail) && tail.owner == owner_t'(k)) begin
                res_valid[k]                = 1'b1;
                res_data[k*DATA_W +: DATA_W] = tail.data;
            end
        end
    end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import slot_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ*DATA_W-1:0] req_data,
    input  logic [NREQ*PASS_W-1:0] req_extra,
    output logic [NREQ-1:0]        req_grant,
    output logic [ID_W-1:0]        slot_owner,
    output logic                  iss_valid,
    output logic [ID_W-1:0]        iss_owner,
    output logic [PASS_W-1:0]      iss_left,
    output logic [DATA_W-1:0]      iss_data,
    input  logic                  tail_valid,
    input  logic [ID_W-1:0]        tail_owner,
    input  logic [PASS_W-1:0]      tail_left,
    input  logic [DATA_W-1:0]      tail_data,
    output logic [NREQ-1:0]        res_valid,
    output logic [NREQ*DATA_W-1:0] res_data
);
    owner_t          slot;
    pipe_op_t        tail_op;
    pipe_op_t        held [NREQ];
    logic [NREQ-1:0] take;
    pipe_op_t        iss_op;

    assign tail_op = '{valid: tail_valid, owner: tail_owner, left: tail_left, data: tail_data};

    slot_counter u_cnt (.clk(clk), .rst(rst), .slot(slot));

    for (genvar k = 0; k < NREQ; k++) begin : g_hold
        recirc_hold #(.OWNER(k)) u_hold (
            .clk(clk), .rst(rst), .tail(tail_op), .take(take[k]), .held(held[k])
        );
    end

    issue_select u_sel (
        .clk(clk), .rst(rst), .slot(slot), .held(held),
        .req_valid(req_valid), .req_data(req_data), .req_extra(req_extra),
        .grant(req_grant), .take(take), .iss(iss_op)
    );

    result_router u_res (.tail(tail_op), .res_valid(res_valid), .res_data(res_data));

    assign slot_owner = slot;
    assign iss_valid  = iss_op.valid;
    assign iss_owner  = iss_op.owner;
    assign iss_left   = iss_op.left;
    assign iss_data   = iss_op.data;

    assert_issue_in_owner_slot_R2: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_owner == slot_owner));
    assert_no_foreign_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (req_grant & ~(NREQ'(1) << slot_owner)) == '0);
    assert_result_routed_R7: assert property (@(posedge clk) disable iff (rst)
        (tail_valid && tail_left == '0) |-> (res_valid[tail_owner] && $onehot(res_valid)));
endmodule

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int PW = 3;
    localparam int PIPE_D = 5;
    localparam int MAXC = 1024;
    localparam int ISO_N = 240;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NR-1:0]    req_valid = '0;
    logic [NR*DW-1:0] req_data  = '0;
    logic [NR*PW-1:0] req_extra = '0;
    logic [NR-1:0]    req_grant;
    logic [1:0]       slot_owner;
    logic             iss_valid;
    logic [1:0]       iss_owner;
    logic [PW-1:0]    iss_left;
    logic [DW-1:0]    iss_data;
    logic             tail_valid;
    logic [1:0]       tail_owner;
    logic [PW-1:0]    tail_left;
    logic [DW-1:0]    tail_data;
    logic [NR-1:0]    res_valid;
    logic [NR*DW-1:0] res_data;

    always #5 clk = ~clk;

    slot_arbiter i_slot_arbiter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
        .req_extra(req_extra), .req_grant(req_grant), .slot_owner(slot_owner),
        .iss_valid(iss_valid), .iss_owner(iss_owner), .iss_left(iss_left),
        .iss_data(iss_data), .tail_valid(tail_valid), .tail_owner(tail_owner),
        .tail_left(tail_left), .tail_data(tail_data), .res_valid(res_valid),
        .res_data(res_data)
    );

    // delay-line pipeline model: adds 1 to the operand on every pass
    logic          pv [PIPE_D];
    logic [1:0]    po [PIPE_D];
    logic [PW-1:0] pl [PIPE_D];
    logic [DW-1:0] pd [PIPE_D];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_D; i++) pv[i] <= 1'b0;
        end else begin
            pv[0] <= iss_valid; po[0] <= iss_owner; pl[0] <= iss_left; pd[0] <= iss_data + 1;
            for (int i = 1; i < PIPE_D; i++) begin
                pv[i] <= pv[i-1]; po[i] <= po[i-1]; pl[i] <= pl[i-1]; pd[i] <= pd[i-1];
            end
        end
    end
    assign tail_valid = pv[PIPE_D-1];
    assign tail_owner = po[PIPE_D-1];
    assign tail_left  = pl[PIPE_D-1];
    assign tail_data  = pd[PIPE_D-1];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic          resv   [NR][MAXC];
    logic [DW-1:0] rdata  [NR][MAXC];
    logic [PW-1:0] rleft  [NR][MAXC];
    logic          xres_v [NR][MAXC];
    logic [DW-1:0] xres_d [NR][MAXC];
    logic          log_on = 1'b0;
    logic [DW+1:0] iso_log [MAXC];
    logic          iso_cmp = 1'b0;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", req, what, cyc, got, exp);
        end
    endtask

    function automatic int next_slot(input int c, input int k);
        return c + ((k - (c % 4) + 4) % 4);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        req_valid = '0;
        for (int k = 0; k < NR; k++)
            for (int c = 0; c < MAXC; c++) begin
                resv[k][c] = 1'b0; xres_v[k][c] = 1'b0;
            end
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
    endtask

    task automatic set_req(input int k, input logic v, input logic [PW-1:0] e, input logic [DW-1:0] d);
        req_valid[k] = v;
        req_extra[k*PW +: PW] = e;
        req_data[k*DW +: DW] = d;
    endtask

    // check this cycle against the bench model, then advance one clock
    task automatic tick();
        logic          eg, any_g, xv;
        logic [1:0]    xo;
        logic [PW-1:0] xl;
        logic [DW-1:0] xd;
        int            s, t;
        #1;
        s = cyc % 4;
        any_g = 1'b0; xv = 1'b0; xo = 2'(s); xl = '0; xd = '0;
        for (int k = 0; k < NR; k++) begin
            eg = (s == k) && req_valid[k] && !resv[k][cyc];
            if (resv[k][cyc] && s == k && req_valid[k])
                check("R6", 64'(req_grant[k]), 64'(eg), $sformatf("grant%0d", k));
            else if (s == k)
                check("R2", 64'(req_grant[k]), 64'(eg), $sformatf("grant%0d", k));
            else
                check("R3", 64'(req_grant[k]), 64'(eg), $sformatf("grant%0d", k));
            if (s == k && resv[k][cyc]) begin
                xv = 1'b1; xl = rleft[k][cyc]; xd = rdata[k][cyc];
            end
            if (eg) begin
                any_g = 1'b1; xv = 1'b1;
                xl = req_extra[k*PW +: PW]; xd = req_data[k*DW +: DW];
                t = cyc;
                for (int j = 1; j <= int'(xl); j++) begin
                    t = next_slot(t + PIPE_D + 1, k);
                    resv[k][t]  = 1'b1;
                    rdata[k][t] = xd + DW'(j);
                    rleft[k][t] = PW'(int'(xl) - j);
                end
                xres_v[k][t + PIPE_D] = 1'b1;
                xres_d[k][t + PIPE_D] = xd + DW'(int'(xl) + 1);
            end
        end
        check("R3", 64'(iss_valid), 64'(xv), "iss_valid");
        if (xv) begin
            check("R4", 64'(iss_owner), 64'(xo), "iss_owner");
            check(any_g ? "R4" : "R5", 64'(iss_left), 64'(xl), "iss_left");
            check(any_g ? "R4" : "R5", 64'(iss_data), 64'(xd), "iss_data");
        end
        for (int k = 0; k < NR; k++) begin
            check("R7", 64'(res_valid[k]), 64'(xres_v[k][cyc]), $sformatf("res_valid%0d", k));
            check("R7", 64'(res_data[k*DW +: DW]), xres_v[k][cyc] ? 64'(xres_d[k][cyc]) : 64'd0,
                  $sformatf("res_data%0d", k));
        end
        if (log_on && cyc < ISO_N + 40) begin
            if (iso_cmp)
                check("R8", 64'({req_grant[0], res_valid[0], res_data[DW-1:0]}), 64'(iso_log[cyc]),
                      "requester0 trace");
            else
                iso_log[cyc] = {req_grant[0], res_valid[0], res_data[DW-1:0]};
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = '0;
        for (int i = 0; i < n; i++) tick();
    endtask

    logic [PW-1:0] pat_e [ISO_N];
    logic [DW-1:0] pat_d [ISO_N];
    logic          pat_v [ISO_N];

    task automatic iso_run(input logic others);
        for (int c = 0; c < ISO_N; c++) begin
            set_req(0, pat_v[c], pat_e[c], pat_d[c]);
            for (int k = 1; k < NR; k++)
                set_req(k, others && ($urandom % 4 != 0), PW'($urandom % 4), $urandom);
            tick();
        end
        idle(40);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        do_reset();
        // R1: counter starts at 0 and steps
        check("R1", 64'(slot_owner), 64'd0, "slot after reset");
        tick();
        check("R1", 64'(slot_owner), 64'd1, "slot step");
        tick(); tick(); tick();
        check("R1", 64'(slot_owner), 64'd0, "slot wrap");

        // R3: requesters 1..3 always pending, requester 0 idle: slot 0 stays empty
        for (int i = 0; i < 16; i++) begin
            set_req(0, 1'b0, '0, '0);
            for (int k = 1; k < NR; k++) set_req(k, 1'b1, '0, DW'(100 * k + i));
            tick();
        end
        idle(12);

        // R5/R6: requester 1 multi-pass ops with a new request always pending
        set_req(1, 1'b1, 3'd3, 32'h1000);
        tick(); tick();
        for (int i = 0; i < 60; i++) begin
            set_req(1, 1'b1, PW'(i % 3), DW'(32'h2000 + i));
            set_req(2, (i % 5) != 0, 3'd2, DW'(32'h3000 + i));
            tick();
        end
        idle(60);

        // random mixed traffic on all requesters
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < NR; k++)
                set_req(k, ($urandom % 3) != 0, PW'($urandom % 8), $urandom);
            tick();
        end
        idle(80);

        // R8: same requester-0 pattern alone, then against random neighbours
        for (int c = 0; c < ISO_N; c++) begin
            pat_v[c] = ($urandom % 2) != 0;
            pat_e[c] = PW'($urandom % 5);
            pat_d[c] = $urandom;
        end
        do_reset();
        log_on = 1'b1; iso_cmp = 1'b0;
        iso_run(1'b0);
        do_reset();
        iso_cmp = 1'b1;
        iso_run(1'b1);
        log_on = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule